// File: doc/BRIEF.md
# Interrupt Line Pending/Active State Tracker

This block keeps the pending and active state of eight physical interrupt lines and offers the best waiting interrupt to a single CPU. Each line is set up as level-sensitive, edge-sensitive or message-style. Each line has a 3-bit priority, where a lower number is more urgent. The CPU takes an interrupt with an acknowledge and ends it in one of two ways. In combined mode, EOI drops the running priority and also deactivates the named interrupt. In split mode, EOI only drops the running priority, and the interrupt stays active until a separate deactivate arrives. That deactivate may come from a bank of virtual list registers.

A software port can set an interrupt's active bit before a guest is entered, without any acknowledge. While that bit is set, a level line that is still asserted stays held off. When the interrupt is deactivated, the line is looked at again. An edge that arrives while the interrupt is active is remembered as pending-and-active. It is offered again only after deactivation. Message-style lines have no active state.

The running priorities of nested interrupts are kept on a four-entry stack. The CPU request output is raised only when an eligible interrupt is strictly more urgent than the running priority.

Top module: `irq_dist_tracker`

## Requirements
- R1: After reset, no line is pending or active, `irq_out` is low, `ack_valid` is low and `run_prio` reads the idle value 8.
- R2: A line whose active bit is set never raises `irq_out` and is never returned by an acknowledge, even while it is pending.
- R3: The pending bit of a level line equals the input as sampled at the previous clock edge. After deactivation, the line is offered again only if the input is still high.
- R4: On an edge line, a rising input latches pending. A rise while the line is active gives pending-and-active. After deactivation, the line is offered again only if such a rise occurred.
- R5: A force write sets the active bit of the addressed non-message line one cycle later, with no acknowledge involved.
- R6: With `eoi_split`=1, EOI only pops the running priority and leaves the interrupt active until a deactivate. With `eoi_split`=0, EOI also clears the active bit of the interrupt named by `eoi_id`.
- R7: A message-style line never becomes active. Acknowledging it clears its pending bit.
- R8: An acknowledge selects the eligible line with the lowest priority number, breaking ties toward the lowest ID. It sets that line active, clears its latched edge, and reports `ack_valid`=1, `ack_spurious`=0 and the ID one cycle after `ack_req`.
- R9: The running-priority stack holds 4 entries. An acknowledge that finds no line to take, finds the stack full, or coincides with `eoi_req` reports `ack_spurious`=1 with `ack_id`=0 and changes no state.
- R10: An EOI while the stack is empty changes no state, and `eoi_err` is high for the following cycle.
- R11: `irq_out` is high exactly when some pending, non-active line has a priority number strictly below `run_prio`.
- R12: A deactivate addressed to a line that is not active leaves that line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 8 | Physical interrupt inputs |
| cfg_edge | input | 8 | 1 = edge-sensitive line |
| cfg_msg | input | 8 | 1 = message-style line (overrides cfg_edge) |
| cfg_prio | input | 24 | Per-line 3-bit priority, line i at bits [3i+2:3i] |
| eoi_split | input | 1 | 1 = EOI drops priority only |
| ack_req | input | 1 | CPU acknowledge request |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_spurious | output | 1 | Response carried no interrupt |
| ack_id | output | 3 | Acknowledged line ID |
| eoi_req | input | 1 | End of interrupt |
| eoi_id | input | 3 | Line ended (used in combined mode) |
| deact_req | input | 1 | Deactivate request |
| deact_id | input | 3 | Line to deactivate |
| force_req | input | 1 | Software write that sets an active bit |
| force_id | input | 3 | Line to force active |
| irq_out | output | 1 | Interrupt request to the CPU |
| run_prio | output | 4 | Current running priority, 8 when idle |
| eoi_err | output | 1 | EOI with empty stack, one cycle |
| pend_state | output | 8 | Pending bit per line |
| act_state | output | 8 | Active bit per line |

## Verification
Several properties are checked on every cycle. The arbiter's choice must be pending and not active. A pushed priority must be more urgent than the current top of the stack, and the stack must never be pushed while full. Message lines never turn active after an acknowledge. Level lines track the sampled input. A late edge on an active edge line must show as pending-and-active. A split EOI must keep the interrupt active, and a force must set the active bit.

Other behaviours can only be shown by the bench's scenarios. These are the lowest-ID tie-break, re-signalling after deactivation with the line still high or a latched edge, and a spurious reply when four nested interrupts fill the stack. The bench also shows the difference between the two EOI modes.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_MSG   = 2'd2
  } trig_e;

  // Message style wins over edge when both configuration bits are set.
  function automatic trig_e trig_of(input logic is_edge, input logic is_msg);
    if (is_msg)  return TRIG_MSG;
    if (is_edge) return TRIG_EDGE;
    return TRIG_LEVEL;
  endfunction

endpackage

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_dist_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_in,
  input  trig_e trig,
  input  logic  ack_hit,
  input  logic  force_hit,
  input  logic  deact_hit,
  output logic  pend,
  output logic  act
);

  logic line_prev;
  logic lvl_q;
  logic latch_q;
  logic act_q;
  logic rise;
  logic act_next;

  // Named internal event: a rising edge seen at this clock.
  assign rise = line_in & ~line_prev;

  always_comb begin
    if (trig == TRIG_MSG) act_next = 1'b0;
    else act_next = (act_q & ~deact_hit) | ack_hit | force_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_prev <= 1'b0;
      lvl_q     <= 1'b0;
      latch_q   <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      line_prev <= line_in;
      lvl_q     <= line_in;
      latch_q   <= (latch_q & ~ack_hit) | rise;
      act_q     <= act_next;
    end
  end

  assign pend = (trig == TRIG_LEVEL) ? lvl_q : latch_q;
  assign act  = act_q;

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_LEVEL) |=> (trig != TRIG_LEVEL || pend == $past(line_in))); // R3

  AST_EDGE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE && act_q && rise && !deact_hit) |=> (trig != TRIG_EDGE || (pend && act))); // R4

  AST_MSG_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_MSG && ack_hit && !rise) |=> (!act && (trig != TRIG_MSG || !pend))); // R7

  AST_DEACT_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_hit && !act_q && !force_hit && !ack_hit) |=> !act); // R12

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    act,
  input  logic [N*PW-1:0] prio_flat,
  input  logic [PW:0]     run_prio,
  output logic            take_ok,
  output logic [IW-1:0]   best_id,
  output logic [PW-1:0]   best_prio
);

  logic [N-1:0] elig;
  logic         found;

  // Strictly more urgent: a lower number wins, so equal priorities do not replace.
  function automatic logic outranks(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return a < b;
  endfunction

  function automatic logic beats_run(input logic [PW-1:0] p, input logic [PW:0] r);
    return {1'b0, p} < r;
  endfunction

  assign elig = pend & ~act;

  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || outranks(prio_flat[i*PW +: PW], best_prio))) begin
        found     = 1'b1;
        best_id   = IW'(i);
        best_prio = prio_flat[i*PW +: PW];
      end
    end
  end

  assign take_ok = found && beats_run(best_prio, run_prio);

  AST_PICK_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[best_id] && !act[best_id])); // R2

endmodule

// File: rtl/prio_stack.sv
module prio_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  parameter int IDLE  = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty,
  output logic         pop_err
);

  logic [W-1:0]  stk [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] tos;
  logic          do_pop;
  logic          do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign tos     = AW'(cnt - CW'(1));
  assign top     = empty ? W'(IDLE) : stk[tos];
  assign do_pop  = pop && !empty;
  assign do_push = push && !full && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pop_err <= 1'b0;
    end else begin
      pop_err <= pop && empty;
      if (do_pop)       cnt <= cnt - CW'(1);
      else if (do_push) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[AW'(cnt)] <= push_val;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9

  AST_PUSH_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_val < top)); // R11

  AST_PUSH_BECOMES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (top == $past(push_val))); // R9

  AST_EMPTY_POP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (pop_err && empty)); // R10

endmodule

// File: rtl/irq_dist_tracker.sv
module irq_dist_tracker
  import irq_dist_pkg::*;
#(
  parameter int N      = 8,
  parameter int PW     = 3,
  parameter int SDEPTH = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int IDLE = 1 << PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    line_in,
  input  logic [N-1:0]    cfg_edge,
  input  logic [N-1:0]    cfg_msg,
  input  logic [N*PW-1:0] cfg_prio,
  input  logic            eoi_split,
  input  logic            ack_req,
  output logic            ack_valid,
  output logic            ack_spurious,
  output logic [IW-1:0]   ack_id,
  input  logic            eoi_req,
  input  logic [IW-1:0]   eoi_id,
  input  logic            deact_req,
  input  logic [IW-1:0]   deact_id,
  input  logic            force_req,
  input  logic [IW-1:0]   force_id,
  output logic            irq_out,
  output logic [PW:0]     run_prio,
  output logic            eoi_err,
  output logic [N-1:0]    pend_state,
  output logic [N-1:0]    act_state
);

  logic          take_ok;
  logic [IW-1:0] best_id;
  logic [PW-1:0] best_prio;
  logic          stk_full;
  logic          stk_empty;
  logic          ack_take;
  logic          eoi_live;
  logic [N-1:0]  ack_hit;
  logic [N-1:0]  deact_hit;
  logic [N-1:0]  force_hit;

  // Named internal events.
  assign ack_take = ack_req && !eoi_req && take_ok && !stk_full;
  assign eoi_live = eoi_req && !stk_empty;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign ack_hit[g]   = ack_take && (best_id == IW'(g));
    assign force_hit[g] = force_req && (force_id == IW'(g));
    assign deact_hit[g] = (deact_req && (deact_id == IW'(g))) ||
                          (eoi_live && !eoi_split && (eoi_id == IW'(g)));

    irq_line_state u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_in[g]),
      .trig      (trig_of(cfg_edge[g], cfg_msg[g])),
      .ack_hit   (ack_hit[g]),
      .force_hit (force_hit[g]),
      .deact_hit (deact_hit[g]),
      .pend      (pend_state[g]),
      .act       (act_state[g])
    );
  end

  irq_arbiter #(.N(N), .PW(PW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_state),
    .act       (act_state),
    .prio_flat (cfg_prio),
    .run_prio  (run_prio),
    .take_ok   (take_ok),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  prio_stack #(.DEPTH(SDEPTH), .W(PW + 1), .IDLE(IDLE)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_take),
    .push_val ({1'b0, best_prio}),
    .pop      (eoi_req),
    .top      (run_prio),
    .full     (stk_full),
    .empty    (stk_empty),
    .pop_err  (eoi_err)
  );

  assign irq_out = take_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid    <= 1'b0;
      ack_spurious <= 1'b0;
      ack_id       <= '0;
    end else begin
      ack_valid    <= ack_req;
      ack_spurious <= ack_req && !ack_take;
      ack_id       <= ack_take ? best_id : '0;
    end
  end

  AST_ACK_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_spurious) |-> $past(irq_out)); // R11

  AST_FORCE_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !cfg_msg[force_id]) |=> act_state[$past(force_id)]); // R5

  AST_SPLIT_EOI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && eoi_split && act_state[eoi_id] && !(deact_req && deact_id == eoi_id))
      |=> act_state[$past(eoi_id)]); // R6

endmodule

// File: tb/test_irq_dist_tracker.sv
module test_irq_dist_tracker;
  localparam int N = 8, PW = 3, IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic [N-1:0] cfg_edge = 8'b1110_0110;
  logic [N-1:0] cfg_msg  = 8'b0000_1000;
  logic [N*PW-1:0] cfg_prio = {3'd7, 3'd6, 3'd6, 3'd1, 3'd4, 3'd2, 3'd2, 3'd5};
  logic eoi_split = 1'b0;
  logic ack_req = 1'b0, eoi_req = 1'b0, deact_req = 1'b0, force_req = 1'b0;
  logic [IW-1:0] eoi_id = '0, deact_id = '0, force_id = '0;
  logic ack_valid, ack_spurious, irq_out, eoi_err;
  logic [IW-1:0] ack_id;
  logic [PW:0] run_prio;
  logic [N-1:0] pend_state, act_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit spur; int id; string tag; } exp_t;
  exp_t expq[$];

  irq_dist_tracker i_irq_dist_tracker (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_edge(cfg_edge), .cfg_msg(cfg_msg),
    .cfg_prio(cfg_prio), .eoi_split(eoi_split), .ack_req(ack_req), .ack_valid(ack_valid),
    .ack_spurious(ack_spurious), .ack_id(ack_id), .eoi_req(eoi_req), .eoi_id(eoi_id),
    .deact_req(deact_req), .deact_id(deact_id), .force_req(force_req), .force_id(force_id),
    .irq_out(irq_out), .run_prio(run_prio), .eoi_err(eoi_err),
    .pend_state(pend_state), .act_state(act_state)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_ack(input bit spur, input int id, input string tag);
    exp_t e;
    e.spur = spur; e.id = id; e.tag = tag;
    expq.push_back(e);
    ack_req = 1'b1; tick(); ack_req = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    eoi_req = 1'b1; eoi_id = IW'(id); tick(); eoi_req = 1'b0;
  endtask

  task automatic do_deact(input int id);
    deact_req = 1'b1; deact_id = IW'(id); tick(); deact_req = 1'b0;
  endtask

  task automatic do_force(input int id);
    force_req = 1'b1; force_id = IW'(id); tick(); force_req = 1'b0;
  endtask

  task automatic pulse_line(input int i);
    line_in[i] = 1'b1; tick(); line_in[i] = 1'b0; tick();
  endtask

  // Monitor: pops expected acknowledge responses as the design produces them.
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected ack actual id=%0d spur=%0d expected none", ack_id, ack_spurious);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (ack_spurious != e.spur || int'(ack_id) != e.id) begin
          errors++;
          $display("FAIL %s ack actual spur=%0d id=%0d expected spur=%0d id=%0d",
                   e.tag, ack_spurious, ack_id, e.spur, e.id);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 pend", int'(pend_state), 0);
    chk("R1 act", int'(act_state), 0);
    chk("R1 irq", int'(irq_out), 0);
    chk("R1 run_prio", int'(run_prio), 8);
    chk("R1 ack_valid", int'(ack_valid), 0);

    // Level line 0, priority 5
    line_in[0] = 1'b1; tick();
    chk("R3 level pend", int'(pend_state[0]), 1);
    chk("R11 irq eligible", int'(irq_out), 1);
    do_force(0);
    chk("R5 force act", int'(act_state[0]), 1);
    chk("R2 active held off", int'(irq_out), 0);
    chk("R3 still pending", int'(pend_state[0]), 1);
    do_ack(1'b1, 0, "R9 nothing eligible");
    chk("R9 run unchanged", int'(run_prio), 8);
    chk("R2 act kept", int'(act_state[0]), 1);
    do_deact(0);
    chk("R3 deact act", int'(act_state[0]), 0);
    chk("R3 resignal line high", int'(irq_out), 1);
    do_force(0);
    line_in[0] = 1'b0; tick();
    do_deact(0);
    chk("R3 no resignal line low", int'(irq_out), 0);
    chk("R3 pend low", int'(pend_state[0]), 0);

    // Edge lines 1 and 2, both priority 2
    line_in[2:1] = 2'b11; tick(); line_in[2:1] = 2'b00; tick();
    chk("R4 edge latched", int'(pend_state[2:1]), 3);
    do_ack(1'b0, 1, "R8 tie lowest id");
    chk("R8 act set", int'(act_state[1]), 1);
    chk("R8 latch cleared", int'(pend_state[1]), 0);
    chk("R9 run pushed", int'(run_prio), 2);
    chk("R11 equal prio no irq", int'(irq_out), 0);
    pulse_line(1);
    chk("R4 pending+active pend", int'(pend_state[1]), 1);
    chk("R4 pending+active act", int'(act_state[1]), 1);
    eoi_split = 1'b1;
    do_eoi(1);
    chk("R6 split eoi run", int'(run_prio), 8);
    chk("R6 split eoi keeps act", int'(act_state[1]), 1);
    chk("R11 irq after drop", int'(irq_out), 1);
    do_ack(1'b0, 2, "R2 skip active line1");
    do_deact(1);
    chk("R4 deact keeps latch", int'(pend_state[1]), 1);
    chk("R4 deact act", int'(act_state[1]), 0);
    chk("R11 not strictly better", int'(irq_out), 0);
    do_eoi(2);
    chk("R6 split act2 kept", int'(act_state[2]), 1);
    do_deact(2);
    chk("R4 no edge no resignal", int'(pend_state[2]), 0);
    do_ack(1'b0, 1, "R4 latched edge resignals");
    eoi_split = 1'b0;
    do_eoi(1);
    chk("R6 combined eoi clears act", int'(act_state[1]), 0);
    chk("R6 combined eoi run", int'(run_prio), 8);

    // Message line 3, priority 4
    pulse_line(3);
    chk("R7 msg pend", int'(pend_state[3]), 1);
    do_ack(1'b0, 3, "R7 msg ack");
    chk("R7 msg no act", int'(act_state[3]), 0);
    chk("R7 msg pend cleared", int'(pend_state[3]), 0);
    do_eoi(3);
    chk("R10 no err on valid eoi", int'(eoi_err), 0);
    do_eoi(0);
    chk("R10 empty eoi err", int'(eoi_err), 1);
    chk("R10 run idle", int'(run_prio), 8);
    tick();
    chk("R10 err one cycle", int'(eoi_err), 0);

    // Fill the stack with four nested interrupts
    pulse_line(5);
    do_ack(1'b0, 5, "R8 line5");
    line_in[0] = 1'b1; tick();
    do_ack(1'b0, 0, "R8 line0 nested");
    pulse_line(3);
    do_ack(1'b0, 3, "R8 line3 nested");
    pulse_line(1);
    do_ack(1'b0, 1, "R8 line1 nested");
    chk("R9 run at depth 4", int'(run_prio), 2);
    line_in[4] = 1'b1; tick();
    chk("R11 irq better than run", int'(irq_out), 1);
    do_ack(1'b1, 0, "R9 stack full");
    chk("R9 full no act", int'(act_state[4]), 0);
    chk("R9 full run kept", int'(run_prio), 2);
    do_deact(4);
    chk("R12 deact idle act", int'(act_state[4]), 0);
    chk("R12 deact idle pend", int'(pend_state[4]), 1);
    do_eoi(1);
    do_eoi(3);
    do_eoi(0);
    chk("R6 unwind run", int'(run_prio), 6);
    chk("R6 unwind act0", int'(act_state[0]), 0);
    chk("R3 line0 still pend", int'(pend_state[0]), 1);

    tick(); tick();
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R8 missing acks actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule